// File: doc/BRIEF.md
# Paged 24-Hour Time-of-Day Keeper with Digit Editing

This block keeps the time of day as three BCD digit pairs (hours, minutes, seconds) and moves it forward on a one-second enable pulse. Its output is a four-digit display image. The page key selects between two views: hours with minutes, or minutes with seconds. A lit decimal point stands in for the separator between the two fields that are shown.

Set mode is toggled by the set key. On entry, an edit copy of hours and minutes is taken. A move key steps a cursor across the four edit digits. A plus key raises the digit under the cursor, and the legal range of that digit limits the result. The digit under the cursor blinks, driven by a square wave that toggles on each blink tick. When set mode is left, the edited hours and minutes become the running time, the seconds start again from zero, and counting continues.

All key and tick inputs are single-cycle pulses that are already debounced. Display scanning, segment decoding and tick generation belong to the surrounding logic.

Top module: `pgclk_top`

## Requirements
- R1: Outside set mode, each `tick_sec` pulse advances the time by one second. Seconds run 00..59 and carry into minutes. Minutes run 00..59 and carry into hours. After 23:59:59 the time becomes 00:00:00.
- R2: `disp_bcd` holds four BCD digits, leftmost in [15:12]. On page 0 the layout is {hour tens, hour ones, minute tens, minute ones}. On page 1 it is {minute tens, minute ones, second tens, second ones}. Each `key_page` pulse flips the page. The page is 0 after reset.
- R3: `disp_dp` is always 4'b0100, which lights the point of the second digit from the left as the field separator.
- R4: A `key_set` pulse toggles set mode. On entry, the edit digits are loaded with the current hours and minutes and the cursor goes to the leftmost position. While set mode is active, `disp_bcd` shows the edit digits in the page-0 layout, whatever the page.
- R5: In set mode, `key_move` moves the cursor one position to the right, and from the rightmost position back to the leftmost. Outside set mode, `key_move` has no visible effect.
- R6: In set mode, `key_plus` raises the digit under the cursor by one with wrap to zero. Hour tens runs 0..2. Hour ones runs 0..9, or 0..3 when hour tens is 2. Minute tens runs 0..5. Minute ones runs 0..9. When hour tens becomes 2 while hour ones is above 3, hour ones is set to 3. Outside set mode, `key_plus` has no visible effect.
- R7: A blink square wave is low after reset and toggles on each `tick_blink`. In set mode, while the wave is high, `disp_blank` has only the cursor's bit set (bit 3 = leftmost). In all other cases `disp_blank` is zero.
- R8: While set mode is active, the stored time does not advance. When set mode is left, the edit hours and minutes are loaded, seconds become 00, and the first `tick_sec` after that makes seconds 01.
- R9: `key_clear` zeroes hours, minutes and seconds, and also the edit digits, in either mode.
- R10: After reset the time is 00:00:00, set mode is off, page 0 is selected and `disp_blank` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sec | input | 1 | One-second enable pulse |
| tick_blink | input | 1 | Blink-rate tick; toggles the blink wave |
| key_page | input | 1 | Page toggle pulse |
| key_set | input | 1 | Set-mode toggle pulse |
| key_move | input | 1 | Edit cursor step pulse |
| key_plus | input | 1 | Edit digit increment pulse |
| key_clear | input | 1 | Time clear pulse |
| disp_bcd | output | 16 | Four BCD digits, leftmost in [15:12] |
| disp_blank | output | 4 | Per-digit blank mask, bit 3 leftmost |
| disp_dp | output | 4 | Per-digit decimal point mask, bit 3 leftmost |

## Verification
On every cycle, the assertions check the following:
- every digit pair stays in its legal range, and the hour edit digits never form a value above 23;
- the stored time holds still through set mode;
- seconds are zero after leaving set mode;
- a clear leaves all-zero time;
- the day wrap lands on 00:00:00;
- blanking appears only in set mode and only on one digit;
- the page changes only on a page key.

Only the directed scenarios can show the following:
- the exact digit sequences of each edit position, including the clamp of hour ones;
- the cursor order and its wrap;
- the page layouts;
- that move and plus outside set mode leave the display unchanged.

// File: rtl/pgclk_pkg.sv
package pgclk_pkg;
  localparam int unsigned DW     = 4;              // bits per BCD digit
  localparam int unsigned NPOS   = 4;              // display positions
  localparam int unsigned CW     = $clog2(NPOS);   // cursor width
  localparam int unsigned NFIELD = 3;              // sec, min, hour
  localparam int unsigned COLON_POS = 2;           // dp bit used as separator

  localparam int unsigned F_SEC = 0;
  localparam int unsigned F_MIN = 1;
  localparam int unsigned F_HR  = 2;

  // edit positions, index = bit in blank mask, 3 = leftmost
  localparam int unsigned P_HT = 3;
  localparam int unsigned P_HO = 2;
  localparam int unsigned P_MT = 1;
  localparam int unsigned P_MO = 0;

  typedef logic [DW-1:0] bcd_t;
  typedef struct packed {
    bcd_t tens;
    bcd_t ones;
  } pair_t;

  localparam bcd_t ONES_MAX = bcd_t'(9);
  localparam bcd_t SIX_TOP  = bcd_t'(5);   // tens limit of sec/min
  localparam bcd_t HT_MAX   = bcd_t'(2);   // hour tens limit
  localparam bcd_t HO_LIM   = bcd_t'(3);   // hour ones limit at hour tens 2
endpackage

// File: rtl/pgclk_pair_ctr.sv
module pgclk_pair_ctr
  import pgclk_pkg::*;
#(
  parameter bcd_t TENS_MAX  = SIX_TOP,
  parameter bcd_t ONES_LAST = ONES_MAX
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  load,
  input  pair_t load_val,
  input  logic  inc,
  output pair_t value,
  output logic  carry
);
  pair_t q, d;
  logic  at_top;

  always_comb begin
    at_top = (q.tens == TENS_MAX) && (q.ones == ONES_LAST);
    carry  = inc && at_top;
    d      = q;
    if (clr) begin
      d = '0;
    end else if (load) begin
      d = load_val;
    end else if (inc) begin
      if (at_top) begin
        d = '0;
      end else if (q.ones == ONES_MAX) begin
        d.ones = '0;
        d.tens = q.tens + 1'b1;
      end else begin
        d.ones = q.ones + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign value = q;

  AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (q.ones <= ONES_MAX) && (q.tens <= TENS_MAX) &&
    !((q.tens == TENS_MAX) && (q.ones > ONES_LAST))); // R1
endmodule

// File: rtl/pgclk_editor.sv
module pgclk_editor
  import pgclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 active,
  input  logic                 enter,
  input  logic                 clear,
  input  logic                 move,
  input  logic                 plus,
  input  bcd_t [NPOS-1:0]      cur_time,
  output bcd_t [NPOS-1:0]      edit_dig,
  output logic [CW-1:0]        cursor
);
  bcd_t [NPOS-1:0] dig_q, dig_d;
  logic [CW-1:0]   cur_q, cur_d;

  always_comb begin
    cur_d = cur_q;
    if (enter)
      cur_d = CW'(NPOS-1);
    else if (active && move)
      cur_d = (cur_q == '0) ? CW'(NPOS-1) : cur_q - 1'b1;
  end

  always_comb begin
    dig_d = dig_q;
    if (clear) begin
      dig_d = '0;
    end else if (enter) begin
      dig_d = cur_time;
    end else if (active && plus) begin
      if (cur_q == CW'(P_HT)) begin
        dig_d[P_HT] = (dig_q[P_HT] >= HT_MAX) ? '0 : dig_q[P_HT] + 1'b1;
        if ((dig_d[P_HT] == HT_MAX) && (dig_q[P_HO] > HO_LIM))
          dig_d[P_HO] = HO_LIM;
      end else if (cur_q == CW'(P_HO)) begin
        if (dig_q[P_HO] >= ((dig_q[P_HT] == HT_MAX) ? HO_LIM : ONES_MAX))
          dig_d[P_HO] = '0;
        else
          dig_d[P_HO] = dig_q[P_HO] + 1'b1;
      end else if (cur_q == CW'(P_MT)) begin
        dig_d[P_MT] = (dig_q[P_MT] >= SIX_TOP) ? '0 : dig_q[P_MT] + 1'b1;
      end else begin
        dig_d[P_MO] = (dig_q[P_MO] >= ONES_MAX) ? '0 : dig_q[P_MO] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0;
      cur_q <= CW'(NPOS-1);
    end else begin
      dig_q <= dig_d;
      cur_q <= cur_d;
    end
  end

  assign edit_dig = dig_q;
  assign cursor   = cur_q;

  AST_EDIT_HOURS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_q[P_HT] <= HT_MAX) &&
    !((dig_q[P_HT] == HT_MAX) && (dig_q[P_HO] > HO_LIM))); // R6
  AST_ENTER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    enter && !clear |=> (cur_q == CW'(NPOS-1)) && (dig_q == $past(cur_time))); // R4
endmodule

// File: rtl/pgclk_view.sv
module pgclk_view
  import pgclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_blink,
  input  logic                 key_page,
  input  logic                 set_active,
  input  pair_t                hh,
  input  pair_t                mm,
  input  pair_t                ss,
  input  bcd_t [NPOS-1:0]      edit_dig,
  input  logic [CW-1:0]        cursor,
  output logic [NPOS*DW-1:0]   disp_bcd,
  output logic [NPOS-1:0]      disp_blank,
  output logic [NPOS-1:0]      disp_dp
);
  logic page_q, page_d;
  logic sq_q, sq_d;
  localparam logic [NPOS-1:0] ONE_HOT0 = {{(NPOS-1){1'b0}}, 1'b1};

  always_comb begin
    page_d = key_page   ? !page_q : page_q;
    sq_d   = tick_blink ? !sq_q   : sq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 1'b0;
      sq_q   <= 1'b0;
    end else begin
      page_q <= page_d;
      sq_q   <= sq_d;
    end
  end

  always_comb begin
    if (set_active)  disp_bcd = edit_dig;
    else if (page_q) disp_bcd = {mm, ss};
    else             disp_bcd = {hh, mm};
  end

  assign disp_blank = (set_active && sq_q) ? (ONE_HOT0 << cursor) : '0;
  assign disp_dp    = ONE_HOT0 << COLON_POS;

  AST_BLANK_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_blank) |-> set_active); // R7
  AST_BLANK_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_blank)); // R7
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !key_page |=> $stable(page_q)); // R2
endmodule

// File: rtl/pgclk_top.sv
module pgclk_top
  import pgclk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_sec,
  input  logic                 tick_blink,
  input  logic                 key_page,
  input  logic                 key_set,
  input  logic                 key_move,
  input  logic                 key_plus,
  input  logic                 key_clear,
  output logic [NPOS*DW-1:0]   disp_bcd,
  output logic [NPOS-1:0]      disp_blank,
  output logic [NPOS-1:0]      disp_dp
);
  logic set_q, set_d;
  logic enter_set, leave_set;

  assign enter_set = key_set && !set_q;
  assign leave_set = key_set && set_q;

  always_comb set_d = key_set ? !set_q : set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_q <= 1'b0;
    else        set_q <= set_d;
  end

  pair_t           tm     [NFIELD];
  pair_t           ld_val [NFIELD];
  logic [NFIELD:0] cy;
  bcd_t [NPOS-1:0] now_hm, edit_dig;
  logic [CW-1:0]   cursor;

  assign cy[0]         = tick_sec && !set_q;
  assign now_hm        = {tm[F_HR], tm[F_MIN]};
  assign ld_val[F_SEC] = '0;
  assign ld_val[F_MIN] = {edit_dig[P_MT], edit_dig[P_MO]};
  assign ld_val[F_HR]  = {edit_dig[P_HT], edit_dig[P_HO]};

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    pgclk_pair_ctr #(
      .TENS_MAX  ((f == F_HR) ? HT_MAX : SIX_TOP),
      .ONES_LAST ((f == F_HR) ? HO_LIM : ONES_MAX)
    ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (key_clear),
      .load     (leave_set),
      .load_val (ld_val[f]),
      .inc      (cy[f]),
      .value    (tm[f]),
      .carry    (cy[f+1])
    );
  end

  pgclk_editor u_edit (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (set_q && !key_set),
    .enter    (enter_set),
    .clear    (key_clear),
    .move     (key_move),
    .plus     (key_plus),
    .cur_time (now_hm),
    .edit_dig (edit_dig),
    .cursor   (cursor)
  );

  pgclk_view u_view (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_blink (tick_blink),
    .key_page   (key_page),
    .set_active (set_q),
    .hh         (tm[F_HR]),
    .mm         (tm[F_MIN]),
    .ss         (tm[F_SEC]),
    .edit_dig   (edit_dig),
    .cursor     (cursor),
    .disp_bcd   (disp_bcd),
    .disp_blank (disp_blank),
    .disp_dp    (disp_dp)
  );

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cy[NFIELD] && !key_clear |=>
      (tm[F_HR] == '0) && (tm[F_MIN] == '0) && (tm[F_SEC] == '0)); // R1
  AST_SET_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    set_q && !key_set && !key_clear |=>
      $stable(now_hm) && $stable(tm[F_SEC])); // R8
  AST_LEAVE_SEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    leave_set && !key_clear |=> (tm[F_SEC] == '0)); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    key_clear |=>
      (tm[F_HR] == '0) && (tm[F_MIN] == '0) && (tm[F_SEC] == '0)); // R9
endmodule

// File: tb/tb_pgclk_top.sv
module tb_pgclk_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  keys = '0;   // 0 sec,1 blink,2 page,3 set,4 move,5 plus,6 clear
  logic [15:0] disp_bcd;
  logic [3:0]  disp_blank, disp_dp;
  int          n_chk = 0;
  int          n_bad = 0;

  localparam int K_SEC = 0, K_BLINK = 1, K_PAGE = 2, K_SET = 3,
                 K_MOVE = 4, K_PLUS = 5, K_CLR = 6;

  always #2.5 clk = ~clk;

  pgclk_top dut (
    .clk(clk), .rst_n(rst_n),
    .tick_sec(keys[K_SEC]), .tick_blink(keys[K_BLINK]),
    .key_page(keys[K_PAGE]), .key_set(keys[K_SET]),
    .key_move(keys[K_MOVE]), .key_plus(keys[K_PLUS]),
    .key_clear(keys[K_CLR]),
    .disp_bcd(disp_bcd), .disp_blank(disp_blank), .disp_dp(disp_dp)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hit(input int k, input int times = 1);
    for (int i = 0; i < times; i++) begin
      @(negedge clk); keys[k] = 1'b1;
      @(negedge clk); keys[k] = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R10 time", disp_bcd, 16'h0000);
    check("R10 blank", {12'h0, disp_blank}, 16'h0000);
    check("R3 dp", {12'h0, disp_dp}, 16'h0004);
  endtask

  task automatic t_count;
    hit(K_SEC, 61);
    check("R1 page0 after 61s", disp_bcd, 16'h0001);
    hit(K_PAGE);
    check("R2 page1 mm:ss", disp_bcd, 16'h0101);
    check("R3 dp page1", {12'h0, disp_dp}, 16'h0004);
    hit(K_PAGE);
    check("R2 back to page0", disp_bcd, 16'h0001);
  endtask

  task automatic t_edit;
    hit(K_SET);
    check("R4 edit copy", disp_bcd, 16'h0001);
    check("R7 wave low", {12'h0, disp_blank}, 16'h0000);
    hit(K_PAGE);
    check("R4 page ignored in set", disp_bcd, 16'h0001);
    hit(K_PAGE);
    hit(K_BLINK);
    check("R7 blink leftmost", {12'h0, disp_blank}, 16'h0008);
    hit(K_MOVE);
    check("R5 cursor right", {12'h0, disp_blank}, 16'h0004);
    hit(K_PLUS, 9);
    check("R6 hour ones 9", disp_bcd, 16'h0901);
    hit(K_PLUS);
    check("R6 hour ones wrap", disp_bcd, 16'h0001);
    hit(K_PLUS, 9);
    hit(K_MOVE, 3);
    check("R5 cursor wraps", {12'h0, disp_blank}, 16'h0008);
    hit(K_PLUS, 2);
    check("R6 hour clamp 23", disp_bcd, 16'h2301);
    hit(K_PLUS);
    check("R6 hour tens wrap", disp_bcd, 16'h0301);
    hit(K_PLUS, 2);
    hit(K_MOVE);
    hit(K_PLUS);
    check("R6 hour ones wrap at 2x", disp_bcd, 16'h2001);
    hit(K_MOVE);
    hit(K_PLUS, 5);
    check("R6 minute tens 5", disp_bcd, 16'h2051);
    hit(K_PLUS);
    check("R6 minute tens wrap", disp_bcd, 16'h2001);
    hit(K_PLUS, 5);
    hit(K_MOVE);
    hit(K_PLUS, 8);
    check("R6 minute ones 9", disp_bcd, 16'h2059);
    hit(K_PLUS);
    check("R6 minute ones wrap", disp_bcd, 16'h2050);
    hit(K_PLUS, 9);
    hit(K_SEC, 3);
    check("R8 set shows edit", disp_bcd, 16'h2059);
    hit(K_SET);
    check("R8 loaded hh:mm", disp_bcd, 16'h2059);
    check("R7 no blank outside set", {12'h0, disp_blank}, 16'h0000);
    hit(K_PAGE);
    check("R8 seconds zero", disp_bcd, 16'h5900);
    hit(K_SEC);
    check("R8 counting resumes", disp_bcd, 16'h5901);
  endtask

  task automatic t_ignored;
    hit(K_PLUS);
    hit(K_MOVE);
    check("R5 R6 keys ignored outside set", disp_bcd, 16'h5901);
    hit(K_SET);
    check("R5 cursor reset on entry", {12'h0, disp_blank}, 16'h0008);
    hit(K_SET);
    hit(K_BLINK);
  endtask

  task automatic t_rollover;
    hit(K_SET);
    hit(K_MOVE);
    hit(K_PLUS, 3);
    hit(K_SET);
    hit(K_SEC, 59);
    check("R1 page1 59:59", disp_bcd, 16'h5959);
    hit(K_PAGE);
    check("R1 page0 23:59", disp_bcd, 16'h2359);
    hit(K_SEC);
    check("R1 day wrap hh:mm", disp_bcd, 16'h0000);
    hit(K_PAGE);
    check("R1 day wrap mm:ss", disp_bcd, 16'h0000);
  endtask

  task automatic t_clear;
    hit(K_SEC, 5);
    check("R9 before clear", disp_bcd, 16'h0005);
    hit(K_CLR);
    check("R9 cleared", disp_bcd, 16'h0000);
    hit(K_PAGE);
    hit(K_SET);
    hit(K_PLUS);
    check("R9 edit set 10", disp_bcd, 16'h1000);
    hit(K_CLR);
    check("R9 edit cleared", disp_bcd, 16'h0000);
    hit(K_SET);
    check("R9 time after exit", disp_bcd, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_edit();
    t_ignored();
    t_rollover();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule